// File: doc/BRIEF.md
# Manchester Serial Receiver with Windowed Edge Tracking

This block takes a Manchester-coded serial line and rebuilds the data words carried on it. The line idles high. A frame opens with a start slot that carries a logic 0, so its mid-slot edge falls. Data slots follow, least significant bit first. A rising mid-slot edge decodes as 1 and a falling one as 0. The raw line passes through a small synchroniser before any edge is examined.

A 16-bit up/down counter times the edges. Each accepted mid-slot edge loads the counter with half of the programmed limit (the limit being clock frequency divided by baud rate) and sets it counting down. At zero the counter turns and counts up. The next edge is accepted only once the rising count has reached a quarter of the limit. This window hides the slot-boundary edges that occur between equal bits, and it also hides short glitches. If the count reaches the full limit with no accepted edge, the frame has overrun its timing.

The frame length comes from a length input in normal mode. In long mode the receiver takes 16 bits and then looks at the next slot. If an edge arrives inside the window, that slot is a seventeenth data bit. If the count reaches the limit instead, the slot is the stop level and the frame closes with 16 bits.

Top module: `manchester_rx`

## Requirements
- R1: After reset, `valid`, `err` and `flag17` are low and `word` is zero.
- R2: A rising mid-slot edge decodes as 1 and a falling edge as 0. Data bit k of the frame lands in `word[k]`, so the first bit received is `word[0]`.
- R3: In normal mode (`long_mode`=0) a frame ends after `data_len` bits, with `data_len` from 1 to 16. `valid` then pulses for exactly one cycle while `word` holds the new value.
- R4: While the counter counts down, or is below a quarter of `limit` on the way up, edges are ignored. This covers the slot-boundary edges between equal bits and single-cycle glitches just after a mid-slot edge.
- R5: If the count reaches `limit` before the frame is complete, `err` pulses for one cycle and no `valid` is issued. The receiver then waits for a new start edge and receives the next frame correctly.
- R6: In long mode, a mid-slot edge inside the window of the seventeenth slot completes a 17-bit frame. The bit is stored in `word[16]` and `flag17` is 1.
- R7: In long mode, if the seventeenth slot has no edge, the frame closes as 16 bits when the count reaches `limit`. In that case `valid` pulses, `flag17` is 0 and `err` stays low.
- R8: The bits of `word` above the received length read 0.
- R9: The bit time follows the `limit` input at run time. A limit equal to twice the half-slot length, in clock cycles, decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial line, idle high |
| limit | input | 16 | Counter limit, equal to clock cycles per bit |
| data_len | input | 5 | Data bits per frame in normal mode (1..16) |
| long_mode | input | 1 | Enables the 16/17-bit automatic length mode |
| word | output | 17 | Last received word |
| valid | output | 1 | One-cycle pulse when a word completes |
| flag17 | output | 1 | Last word had 17 data bits |
| err | output | 1 | One-cycle pulse on an edge timeout |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 16-bit maximum normal length, which gives a 17-bit word. At run time it programs limits of 16 and 24, so each bit lasts only a few dozen cycles. With frames that short, every length from a few bits up to the full 17-bit frame fits within the run, along with a timeout partway through a frame and both outcomes of the seventeenth slot. Frames of repeated ones and zeros, and single-cycle glitches placed just after a mid-slot edge, put edges inside the closed window.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    typedef enum logic {
        S_HUNT = 1'b0,
        S_DATA = 1'b1
    } rx_state_t;

    typedef struct packed {
        logic valid;
        logic err;
        logic f17;
    } rx_evt_t;

    typedef struct packed {
        logic edge_seen;
        logic level;
    } line_evt_t;

endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_in,
    output mrx_pkg::line_evt_t  ev
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= rx_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b1;
        else     last <= chain[STAGES-1];
    end

    always_comb begin
        ev.level     = chain[STAGES-1];
        ev.edge_seen = chain[STAGES-1] ^ last;
    end
endmodule

// File: rtl/mrx_timer.sv
module mrx_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             window,
    output logic             timeout
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic             down;
    logic [CNT_W-1:0] n1;
    logic [CNT_W-1:0] quarter;

    assign n1      = limit >> 1;
    assign quarter = limit >> 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (restart) begin
            cnt  <= n1;
            down <= 1'b1;
        end else if (!active) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (down) begin
            if (cnt <= 1) begin
                cnt  <= '0;
                down <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign window  = active && !down && (cnt >= quarter);
    assign timeout = active && !down && (cnt >= limit);

    // R4: while the counter runs down, the window stays closed
    assert_closed_on_down_R4: assert property (@(posedge clk) disable iff (rst)
        restart |=> !window);
endmodule

// File: rtl/mrx_frame.sv
module mrx_frame #(
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  mrx_pkg::line_evt_t    ev,
    input  logic                  window,
    input  logic                  timeout,
    input  logic [LEN_W-1:0]      len,
    input  logic                  long_mode,
    output logic                  restart,
    output logic                  active,
    output logic [MAX_BITS:0]     word,
    output mrx_pkg::rx_evt_t      evt
);
    import mrx_pkg::*;

    localparam int WORD_W = MAX_BITS + 1;
    localparam int BIT_W  = $clog2(WORD_W + 1);
    localparam logic [BIT_W-1:0] FULL = BIT_W'(WORD_W);
    localparam logic [BIT_W-1:0] BASE = BIT_W'(MAX_BITS);

    rx_state_t         state;
    logic [BIT_W-1:0]  idx;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] acc_next;
    logic [BIT_W-1:0]  target;
    logic              take;

    assign active = (state == S_DATA);
    assign target = long_mode ? FULL : BIT_W'(len);
    assign take   = active && ev.edge_seen && window;

    always_comb begin
        restart = take || (!active && ev.edge_seen && !ev.level);
        acc_next = acc;
        acc_next[idx] = ev.level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_HUNT;
            idx   <= '0;
            acc   <= '0;
            word  <= '0;
            evt   <= '0;
        end else begin
            evt.valid <= 1'b0;
            evt.err   <= 1'b0;
            if (!active) begin
                if (ev.edge_seen && !ev.level) begin
                    state <= S_DATA;
                    idx   <= '0;
                    acc   <= '0;
                end
            end else if (take) begin
                acc <= acc_next;
                idx <= idx + 1'b1;
                if (idx + 1'b1 == target) begin
                    word      <= acc_next;
                    evt.valid <= 1'b1;
                    evt.f17   <= (idx + 1'b1 == FULL);
                    state     <= S_HUNT;
                end
            end else if (timeout) begin
                state <= S_HUNT;
                if (long_mode && idx == BASE) begin
                    word      <= acc;
                    evt.valid <= 1'b1;
                    evt.f17   <= 1'b0;
                end else begin
                    evt.err <= 1'b1;
                end
            end
        end
    end

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> !evt.valid);
    assert_valid_idle_R3: assert property (@(posedge clk) disable iff (rst)
        evt.valid |-> state == S_HUNT);
    assert_err_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !(evt.err && evt.valid));
    assert_err_idle_R5: assert property (@(posedge clk) disable iff (rst)
        evt.err |-> state == S_HUNT);
    assert_flag_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(evt.f17) |-> evt.valid);
    assert_top_bit_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !evt.f17) |-> !word[MAX_BITS]);
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
    parameter int CNT_W    = 16,
    parameter int MAX_BITS = 16,
    parameter int SYNC_N   = 2,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_in,
    input  logic [CNT_W-1:0]    limit,
    input  logic [LEN_W-1:0]    data_len,
    input  logic                long_mode,
    output logic [MAX_BITS:0]   word,
    output logic                valid,
    output logic                flag17,
    output logic                err
);
    import mrx_pkg::*;

    line_evt_t ev;
    rx_evt_t   evt;
    logic      window;
    logic      timeout;
    logic      restart;
    logic      active;

    mrx_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .rx_in(rx_in), .ev(ev)
    );

    mrx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .active(active), .restart(restart),
        .limit(limit), .window(window), .timeout(timeout)
    );

    mrx_frame #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_frame (
        .clk(clk), .rst(rst), .ev(ev), .window(window), .timeout(timeout),
        .len(data_len), .long_mode(long_mode), .restart(restart),
        .active(active), .word(word), .evt(evt)
    );

    assign valid  = evt.valid;
    assign flag17 = evt.f17;
    assign err    = evt.err;
endmodule

// File: tb/sim_manchester_rx.sv
module sim_manchester_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_in = 1'b1;
    logic [15:0] limit = 16'd16;
    logic [4:0]  data_len = 5'd8;
    logic        long_mode = 1'b0;
    logic [16:0] word;
    logic        valid, flag17, err;

    int checks = 0, errors = 0, cycles = 0;
    int nvalid = 0, nerr = 0, runs = 0;
    logic [16:0] cap_word = '0;
    logic        cap_f17 = 1'b0;
    logic        prev_valid = 1'b0;

    manchester_rx u0 (
        .clk(clk), .rst(rst), .rx_in(rx_in), .limit(limit),
        .data_len(data_len), .long_mode(long_mode), .word(word),
        .valid(valid), .flag17(flag17), .err(err)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (valid) begin
            nvalid++;
            cap_word = word;
            cap_f17  = flag17;
            if (prev_valid) runs++;
        end
        if (err) nerr++;
        prev_valid = valid;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_in = 1'b1;
        end
    endtask

    task automatic clear();
        nvalid = 0; nerr = 0; runs = 0;
    endtask

    // glitch_bit < 0 means no glitch
    task automatic send(input logic [16:0] bits, input int n, input int h, input int glitch_bit);
        for (int c = 0; c < h; c++) begin @(negedge clk); rx_in = 1'b1; end
        for (int c = 0; c < h; c++) begin @(negedge clk); rx_in = 1'b0; end
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < h; c++) begin @(negedge clk); rx_in = ~bits[i]; end
            for (int c = 0; c < h; c++) begin
                @(negedge clk);
                rx_in = (glitch_bit == i && c == 2) ? ~bits[i] : bits[i];
            end
        end
    endtask

    task automatic frame_ok(input string tag, input logic [16:0] bits, input int n,
                            input int h, input int g, input logic [16:0] exp, input logic f17);
        clear();
        send(bits, n, h, g);
        idle(8 * h + 10);
        check(nvalid == 1, {tag, " valid count"}, nvalid, 1);
        check(nerr == 0, {tag, " err count"}, nerr, 0);
        check(cap_word == exp, {tag, " word"}, cap_word, exp);
        check(cap_f17 == f17, {tag, " flag17"}, cap_f17, f17);
        check(runs == 0, {tag, " valid width R3"}, runs, 0);
    endtask

    task automatic t_reset();
        check(valid == 0 && err == 0 && flag17 == 0, "R1 flags", {valid, err, flag17}, 0);
        check(word == 0, "R1 word", word, 0);
    endtask

    task automatic t_basic();
        limit = 16; data_len = 8; long_mode = 0;
        frame_ok("R2 R3 pattern A5", 17'h000A5, 8, 8, -1, 17'h000A5, 1'b0);
        frame_ok("R2 pattern 3C", 17'h0003C, 8, 8, -1, 17'h0003C, 1'b0);
    endtask

    task automatic t_repeat();
        limit = 16; data_len = 8; long_mode = 0;
        frame_ok("R4 ones", 17'h000FF, 8, 8, -1, 17'h000FF, 1'b0);
        frame_ok("R4 zeros", 17'h00000, 8, 8, -1, 17'h00000, 1'b0);
    endtask

    task automatic t_glitch();
        limit = 16; data_len = 8; long_mode = 0;
        frame_ok("R4 glitch", 17'h00096, 8, 8, 3, 17'h00096, 1'b0);
    endtask

    task automatic t_short();
        limit = 16; data_len = 5; long_mode = 0;
        frame_ok("R8 short", 17'h1FFFF, 5, 8, -1, 17'h0001F, 1'b0);
    endtask

    task automatic t_limit();
        limit = 24; data_len = 12; long_mode = 0;
        frame_ok("R9 limit 24", 17'h00B6D, 12, 12, -1, 17'h00B6D, 1'b0);
        limit = 16;
    endtask

    task automatic t_timeout();
        limit = 16; data_len = 8; long_mode = 0;
        clear();
        send(17'h00002, 3, 8, -1);
        idle(80);
        check(nerr == 1, "R5 err count", nerr, 1);
        check(nvalid == 0, "R5 no valid", nvalid, 0);
        frame_ok("R5 recovery", 17'h0005A, 8, 8, -1, 17'h0005A, 1'b0);
    endtask

    task automatic t_long();
        limit = 16; long_mode = 1; data_len = 8;
        frame_ok("R6 seventeen", 17'h1A5C3, 17, 8, -1, 17'h1A5C3, 1'b1);
        frame_ok("R7 sixteen", 17'h0C3A5, 16, 8, -1, 17'h0C3A5, 1'b0);
        frame_ok("R7 sixteen top0", 17'h08001, 16, 8, -1, 17'h08001, 1'b0);
        long_mode = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        idle(5);
        t_basic();
        t_repeat();
        t_glitch();
        t_short();
        t_limit();
        t_timeout();
        t_long();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule